// File: doc/BRIEF.md
# Iterative Carry-Save Multiply-Accumulate Unit

This block multiplies two 32-bit integers, optionally adding a 64-bit accumulate term, and can return either the low 32 bits of the result or the full 64-bit result. It works over several cycles. On each pass a 12-row carry-save array takes 12 bits of the multiplier and the whole multiplicand. The array folds their partial products into a redundant sum/carry pair that is held in registers between passes. The accumulate term is loaded into that redundant pair before the first pass, so adding it costs no cycle.

The number of passes depends on the multiplier operand. A multiplier that fits in 12 bits needs one pass, one that fits in 24 bits needs two, and any other needs three. Signed operands are judged by their two's-complement range and unsigned operands by their magnitude. After the last pass, a 32-bit carry-propagate adder resolves the redundant pair into binary, one half per cycle. The low half is always delivered. In long mode the high half follows in the next cycle, using the carry saved from the low half.

A host pulses `start` while `busy` is low. It then collects one result word for each `done` pulse, and `resultHigh` tells which half each word is.

Top module: `csaMulAcc`

## Requirements
- R1: After reset `busy`, `done` and `resultHigh` are 0 and `result` is 0.
- R2: With `signedOps`=0, the operands are unsigned and the result word equals the low 32 bits of multiplicand*multiplier (plus accumulate when enabled).
- R3: With `signedOps`=1, both operands are two's complement and the 64-bit result equals the signed product (plus accumulate when enabled), modulo 2^64.
- R4: The pass count N is set by the multiplier. Signed: N=1 for -2048..2047, N=2 for -2^23..2^23-1, else N=3. Unsigned: N=1 below 4096, N=2 below 2^24, else N=3. The low-half `done` appears N+1 rising edges after the edge that accepts `start`.
- R5: With `accEnable`=1, `accValue` (64 bits) is added to the product, and the latency is the same as without accumulation.
- R6: With `longResult`=1, `done` is high on two successive cycles. The first carries bits 31:0 with `resultHigh`=0, and the second carries bits 63:32 with `resultHigh`=1. With `longResult`=0 there is a single `done` with `resultHigh`=0.
- R7: `busy` is high from the cycle after an accepted `start` until the final `done` of that operation. It is low in the cycle where the final `done` is visible.
- R8: A `start` pulse while `busy` is high is ignored. It produces no extra result and does not alter the operation in flight.
- R9: A `start` presented in the cycle where the final `done` is visible is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| multiplicand | input | 32 | First operand, fed whole to the array |
| multiplier | input | 32 | Second operand, consumed 12 bits per pass |
| accValue | input | 64 | Accumulate term |
| accEnable | input | 1 | Add `accValue` to the product |
| signedOps | input | 1 | 1: two's complement operands, 0: unsigned |
| longResult | input | 1 | 1: deliver both halves, 0: low half only |
| busy | output | 1 | Operation in progress |
| done | output | 1 | `result` holds a valid word this cycle |
| resultHigh | output | 1 | The word on `result` is the upper half |
| result | output | 32 | Result word |

## Verification
Two functions coincide: the final result word leaves the block in the same cycle that a new `start` is accepted. The bench provokes this by issuing each operation in the cycle where the previous one shows its final `done`. The scoreboard then requires both the old word and the new operation's words to match, with the new operation's latency counted from that shared cycle. A second overlap is a `start` with different operands raised during a pass. It is judged by an unchanged result and by the absence of any unexpected `done`, which the monitor flags when its queue is empty.

// File: rtl/csa_mac_pkg.sv
package csa_mac_pkg;

  localparam int DATA_W   = 32;
  localparam int CHUNK_W  = 12;
  localparam int PROD_W   = 2 * DATA_W;
  localparam int MAX_PASS = (DATA_W + CHUNK_W - 1) / CHUNK_W;
  localparam int MPL_W    = MAX_PASS * CHUNK_W;
  localparam int CNT_W    = $clog2(MAX_PASS + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS  = 2'd1,
    ST_FINLO = 2'd2,
    ST_FINHI = 2'd3
  } macState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // capture operands, seed sum with accumulate
    logic step;        // run one array pass
    logic lastSigned;  // current chunk is the top signed chunk
    logic signedOp;    // operation is signed
    logic finLo;       // resolve low half
    logic finHi;       // resolve high half
  } macCtl_t;

  typedef struct packed {
    logic [PROD_W-1:0] sum;
    logic [PROD_W-1:0] carry;
  } csaPair_t;

  function automatic csaPair_t csa3(input logic [PROD_W-1:0] a,
                                    input logic [PROD_W-1:0] b,
                                    input logic [PROD_W-1:0] c,
                                    input logic              cin);
    csaPair_t r;
    logic [PROD_W-1:0] maj;
    maj     = (a & b) | (a & c) | (b & c);
    r.sum   = a ^ b ^ c;
    r.carry = {maj[PROD_W-2:0], cin};
    return r;
  endfunction

endpackage

// File: rtl/csaMacCtrl.sv
module csaMacCtrl
  import csa_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] multiplier,
  input  logic              signedOps,
  input  logic              longResult,
  output macCtl_t           ctl,
  output logic              busy,
  output logic              done,
  output logic              resultHigh
);

  macState_t        state;
  logic [CNT_W-1:0] passTotal;
  logic [CNT_W-1:0] passIdx;
  logic [CNT_W-1:0] passNeed;
  logic             longReg;
  logic             signedReg;
  logic             doneReg;
  logic             highReg;
  logic             lastPass;

  // smallest pass count whose chunks cover the multiplier's significant bits
  always_comb begin
    passNeed = CNT_W'(MAX_PASS);
    for (int n = MAX_PASS - 1; n >= 1; n--) begin
      logic [DATA_W-1:0] upper;
      if (signedOps) begin
        upper = DATA_W'($signed(multiplier) >>> (n * CHUNK_W - 1));
        if (upper == '0 || upper == '1) passNeed = CNT_W'(n);
      end else begin
        upper = multiplier >> (n * CHUNK_W);
        if (upper == '0) passNeed = CNT_W'(n);
      end
    end
  end

  assign lastPass = (passIdx == passTotal - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      passTotal <= '0;
      passIdx   <= '0;
      longReg   <= 1'b0;
      signedReg <= 1'b0;
      doneReg   <= 1'b0;
      highReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_PASS;
            passTotal <= passNeed;
            passIdx   <= '0;
            longReg   <= longResult;
            signedReg <= signedOps;
          end
        end
        ST_PASS: begin
          if (lastPass) state <= ST_FINLO;
          else          passIdx <= passIdx + CNT_W'(1);
        end
        ST_FINLO: begin
          doneReg <= 1'b1;
          highReg <= 1'b0;
          state   <= longReg ? ST_FINHI : ST_IDLE;
        end
        ST_FINHI: begin
          doneReg <= 1'b1;
          highReg <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.load       = (state == ST_IDLE) && start;
    ctl.step       = (state == ST_PASS);
    ctl.lastSigned = (state == ST_PASS) && signedReg && lastPass;
    ctl.signedOp   = ctl.load ? signedOps : signedReg;
    ctl.finLo      = (state == ST_FINLO);
    ctl.finHi      = (state == ST_FINHI);
  end

  assign busy       = (state != ST_IDLE);
  assign done       = doneReg;
  assign resultHigh = highReg;

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R7

  AST_FINAL_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (done && (resultHigh || !longReg)) |-> !busy); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> ($stable(passTotal) && $stable(longReg))); // R8

  AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS) |-> (passTotal >= CNT_W'(1) && passTotal <= CNT_W'(MAX_PASS)
                            && passIdx < passTotal)); // R4

  AST_HIGH_FOLLOWS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (done && !resultHigh && longReg) |=> (done && resultHigh)); // R6

  AST_SHORT_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !longReg && !resultHigh) |=> !done); // R6

endmodule

// File: rtl/csaMacDatapath.sv
module csaMacDatapath
  import csa_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  macCtl_t           ctl,
  input  logic [DATA_W-1:0] multiplicand,
  input  logic [DATA_W-1:0] multiplier,
  input  logic [PROD_W-1:0] accValue,
  input  logic              accEnable,
  output logic [DATA_W-1:0] result
);

  logic [PROD_W-1:0] mcandReg;
  logic [MPL_W-1:0]  mplReg;
  logic [PROD_W-1:0] sumReg;
  logic [PROD_W-1:0] carryReg;
  logic              coutReg;
  logic [DATA_W-1:0] resReg;

  logic [CHUNK_W-1:0] chunk;
  logic               negTop;
  logic [PROD_W-1:0]  stSum   [0:CHUNK_W];
  logic [PROD_W-1:0]  stCarry [0:CHUNK_W];
  logic [DATA_W:0]    lowAdd;
  logic [DATA_W-1:0]  highAdd;

  assign chunk  = mplReg[CHUNK_W-1:0];
  // top chunk of a signed multiplier: its MSB row weighs negative
  assign negTop = ctl.lastSigned && chunk[CHUNK_W-1];

  assign stSum[0]   = sumReg;
  assign stCarry[0] = carryReg;

  // one 3:2 compressor row per multiplier bit of the chunk
  for (genvar i = 0; i < CHUNK_W; i++) begin : g_row
    logic [PROD_W-1:0] rowTerm;
    logic              rowCin;
    csaPair_t          rowOut;
    if (i == CHUNK_W - 1) begin : g_top
      assign rowTerm = negTop   ? ~(mcandReg << i) :
                       chunk[i] ?  (mcandReg << i) : '0;
      assign rowCin  = negTop;  // +1 completes the two's complement negation
    end else begin : g_plain
      assign rowTerm = chunk[i] ? (mcandReg << i) : '0;
      assign rowCin  = 1'b0;
    end
    assign rowOut         = csa3(stSum[i], stCarry[i], rowTerm, rowCin);
    assign stSum[i + 1]   = rowOut.sum;
    assign stCarry[i + 1] = rowOut.carry;
  end

  // 32-bit carry-propagate adder, used once per result half
  assign lowAdd  = {1'b0, sumReg[DATA_W-1:0]} + {1'b0, carryReg[DATA_W-1:0]};
  assign highAdd = sumReg[PROD_W-1:DATA_W] + carryReg[PROD_W-1:DATA_W]
                   + DATA_W'(coutReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandReg <= '0;
      mplReg   <= '0;
      sumReg   <= '0;
      carryReg <= '0;
      coutReg  <= 1'b0;
      resReg   <= '0;
    end else begin
      if (ctl.load) begin
        mcandReg <= ctl.signedOp ? PROD_W'($signed(multiplicand))
                                 : PROD_W'(multiplicand);
        mplReg   <= ctl.signedOp ? MPL_W'($signed(multiplier))
                                 : MPL_W'(multiplier);
        sumReg   <= accEnable ? accValue : '0;
        carryReg <= '0;
      end else if (ctl.step) begin
        sumReg   <= stSum[CHUNK_W];
        carryReg <= stCarry[CHUNK_W];
        mcandReg <= mcandReg << CHUNK_W;
        mplReg   <= ctl.signedOp ? MPL_W'($signed(mplReg) >>> CHUNK_W)
                                 : (mplReg >> CHUNK_W);
      end
      if (ctl.finLo) begin
        resReg  <= lowAdd[DATA_W-1:0];
        coutReg <= lowAdd[DATA_W];
      end else if (ctl.finHi) begin
        resReg  <= highAdd;
      end
    end
  end

  assign result = resReg;

  AST_LOAD_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (carryReg == '0)); // R5

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.finLo && !ctl.finHi) |=> $stable(resReg)); // R8

endmodule

// File: rtl/csaMulAcc.sv
module csaMulAcc
  import csa_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] multiplicand,
  input  logic [DATA_W-1:0] multiplier,
  input  logic [PROD_W-1:0] accValue,
  input  logic              accEnable,
  input  logic              signedOps,
  input  logic              longResult,
  output logic              busy,
  output logic              done,
  output logic              resultHigh,
  output logic [DATA_W-1:0] result
);

  macCtl_t ctl;

  csaMacCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .multiplier (multiplier),
    .signedOps  (signedOps),
    .longResult (longResult),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .resultHigh (resultHigh)
  );

  csaMacDatapath i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .accValue     (accValue),
    .accEnable    (accEnable),
    .result       (result)
  );

endmodule

// File: tb/test_csaMulAcc.sv
module test_csaMulAcc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] multiplicand = '0;
  logic [31:0] multiplier = '0;
  logic [63:0] accValue = '0;
  logic        accEnable = 1'b0;
  logic        signedOps = 1'b0;
  logic        longResult = 1'b0;
  logic        busy;
  logic        done;
  logic        resultHigh;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [32:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  csaMulAcc i_csaMulAcc (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .accValue(accValue), .accEnable(accEnable),
    .signedOps(signedOps), .longResult(longResult),
    .busy(busy), .done(done), .resultHigh(resultHigh), .result(result)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected words as the design produces them
  always @(posedge clk) begin
    #3;
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(0, "R8 unexpected done", {31'b0, resultHigh, result}, 64'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({resultHigh, result} == e, t, {31'b0, resultHigh, result}, {31'b0, e});
      end
    end
  end

  function automatic int passesFor(input logic [31:0] b, input logic sg);
    if (sg) begin
      int v;
      v = $signed(b);
      if (v >= -2048 && v <= 2047) return 1;
      if (v >= -8388608 && v <= 8388607) return 2;
      return 3;
    end
    if (b < 32'd4096) return 1;
    if (b < 32'h0100_0000) return 2;
    return 3;
  endfunction

  // driver: called in a cycle where the design is idle or shows its final done
  task automatic runOp(input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] acc, input logic accE,
                       input logic sg, input logic lg, input logic poke);
    logic [63:0] prod;
    logic [63:0] full;
    int nPass, expLat, c;
    string tg;
    if (sg) begin
      logic signed [63:0] sa, sb;
      sa = $signed(a);
      sb = $signed(b);
      prod = sa * sb;
    end else begin
      prod = {32'h0, a} * {32'h0, b};
    end
    full = prod + (accE ? acc : 64'h0);
    tg = sg ? "R3 signed" : "R2 unsigned";
    if (accE) tg = {tg, " R5 acc"};
    expQ.push_back({1'b0, full[31:0]});
    tagQ.push_back({tg, " R6 low"});
    if (lg) begin
      expQ.push_back({1'b1, full[63:32]});
      tagQ.push_back({tg, " R6 high"});
    end
    nPass  = passesFor(b, sg);
    expLat = lg ? nPass + 2 : nPass + 1;
    multiplicand = a; multiplier = b; accValue = acc; accEnable = accE;
    signedOps = sg; longResult = lg; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    c = 0;
    while (c < 40) begin
      @(posedge clk); #2;
      c++;
      if (c == 1) check(busy == 1'b1, "R7 busy during op", {63'b0, busy}, 64'h1);
      if (poke && c == 1) begin
        multiplicand = ~a; multiplier = 32'h7fff_ffff; accEnable = ~accE;
        longResult = ~lg; start = 1'b1;
      end
      if (poke && c == 2) begin
        start = 1'b0;
        multiplicand = a; multiplier = b; accEnable = accE; longResult = lg;
      end
      if (done && (resultHigh || !lg)) break;
    end
    check(c == expLat, accE ? "R5 latency" : "R4 latency", c, expLat);
    check(busy == 1'b0, "R7 busy low at final done", {63'b0, busy}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(posedge clk); #2;
    check(!busy && !done && !resultHigh && result == 0, "R1 reset state",
          {30'b0, busy, done, result}, 64'h0);

    // unsigned, each pass length and boundaries (R2, R4)
    runOp(32'd7, 32'd9, 64'h0, 0, 0, 0, 0);
    runOp(32'h1234_5678, 32'd4095, 64'h0, 0, 0, 1, 0);
    runOp(32'h1234_5678, 32'd4096, 64'h0, 0, 0, 1, 0);
    runOp(32'hdead_beef, 32'h00ff_ffff, 64'h0, 0, 0, 1, 0);
    runOp(32'hdead_beef, 32'h0100_0000, 64'h0, 0, 0, 1, 0);
    runOp(32'hffff_ffff, 32'hffff_ffff, 64'h0, 0, 0, 1, 0);
    runOp(32'h0, 32'hffff_ffff, 64'h0, 0, 0, 0, 0);

    // signed corners (R3, R4)
    runOp(32'hffff_ffff, 32'hffff_ffff, 64'h0, 0, 1, 1, 0);
    runOp(32'h8000_0000, 32'h8000_0000, 64'h0, 0, 1, 1, 0);
    runOp(32'd123456, 32'hffff_f800, 64'h0, 0, 1, 1, 0);
    runOp(32'd123456, 32'd2048, 64'h0, 0, 1, 1, 0);
    runOp(32'h8765_4321, 32'h007f_ffff, 64'h0, 0, 1, 1, 0);
    runOp(32'h8765_4321, 32'h0080_0000, 64'h0, 0, 1, 1, 0);
    runOp(32'h7fff_ffff, 32'hff80_0000, 64'h0, 0, 1, 1, 0);
    runOp(32'h7fff_ffff, 32'h8000_0000, 64'h0, 0, 1, 1, 0);

    // accumulate folded in (R5)
    runOp(32'hffff_fffb, 32'd7, 64'hffff_ffff_ffff_ffff, 1, 1, 1, 0);
    runOp(32'hffff_ffff, 32'hffff_ffff, 64'hffff_ffff_ffff_ffff, 1, 0, 1, 0);
    runOp(32'd1000, 32'd3000, 64'h0000_0001_ffff_ffff, 1, 0, 0, 0);
    runOp(32'h1357_9bdf, 32'hfedc_ba98, 64'h0123_4567_89ab_cdef, 1, 1, 1, 0);

    // start raised mid-operation is ignored (R8)
    runOp(32'h0bad_cafe, 32'h0f0f_0f0f, 64'h5, 1, 0, 1, 1);
    runOp(32'h0000_0003, 32'd5, 64'h0, 0, 1, 0, 1);

    // idle gap, then a fresh start (R9 exercised by all runs above)
    repeat (4) @(posedge clk);
    #2;
    runOp(32'hcafe_f00d, 32'h0000_0abc, 64'h0, 0, 0, 1, 0);

    repeat (6) @(posedge clk);
    #4;
    check(expQ.size() == 0, "R6 all words delivered", expQ.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule